// File: doc/BRIEF.md
# Sector ECC Syndrome Corrector

This block takes two 3-byte Hamming check codes for one 512-byte sector: the code that was stored alongside the data, and the code recomputed from the data as it was read back. It reorders each code into a 24-bit word in ascending parity order and XORs the two words to form a syndrome. From that syndrome it decides whether the sector is clean, whether one data bit has flipped, whether only the stored code is damaged, or whether the damage cannot be repaired. When one data bit has flipped, it reports the byte address in the sector and the bit inside that byte. The caller then inverts that bit in its buffer.

Both codes are presented in parallel with a one-cycle request strobe. The verdict and the location are registered, and a done strobe is raised in the following cycle. The outputs then hold their values until the next request. A small two-state machine controls the strobe. `S_WAIT` is the idle state: a request moves it to `S_DONE` (transition *accept*), and otherwise it stays (transition *idle*). `S_DONE` drives the done strobe: a new request keeps it in `S_DONE` (transition *chain*), and no request returns it to `S_WAIT` (transition *retire*).

Top module: `sector_ecc_fixer`

## Requirements
- R1: When the stored and recomputed codes are identical, the status is 2'b00 (clean).
- R2: Each code bus carries byte 0 on bits 7:0, byte 1 on bits 15:8 and byte 2 on bits 23:16. Each code is repacked into a 24-bit word W as follows:
  - W[5:0] = byte2[7:2]
  - W[13:6] = byte0
  - W[21:14] = byte1
  - W[23:22] = byte2[1:0]

  The syndrome D is the XOR of the two repacked words.
- R3: When each of the twelve bit pairs (D[2k+1], D[2k]) for k = 0..11 contains at least one set bit, the status is 2'b01 (data bit to be corrected).
- R4: For status 2'b01, the bit position output is {D[5], D[3], D[1]}.
- R5: For status 2'b01, the byte address output is {D[23], D[21], D[19], D[17], D[15], D[13], D[11], D[9], D[7]}, with the most significant bit first.
- R6: When exactly one bit of D is set, the status is 2'b10 (code-only error, no data change).
- R7: Every other nonzero D gives status 2'b11 (uncorrectable).
- R8: Whenever the status is not 2'b01, the byte address and bit position outputs are zero.
- R9: The done output is high in exactly those cycles that directly follow a cycle in which the request was high. The status and location outputs change only in the cycle after a request, and hold their values otherwise.
- R10: While reset is asserted and immediately after it, done is 0 and the status, byte address and bit position outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_req | input | 1 | Request strobe: both codes are valid |
| code_stored | input | 24 | Code read back from the spare area {byte2, byte1, byte0} |
| code_calc | input | 24 | Code recomputed over the sector {byte2, byte1, byte0} |
| chk_done | output | 1 | Result valid strobe, one cycle after the request |
| chk_status | output | 2 | 00 clean, 01 data fix, 10 code-only, 11 uncorrectable |
| fix_byte | output | 9 | Byte address of the bit to flip (status 01 only) |
| fix_bit | output | 3 | Bit index inside that byte (status 01 only) |

## Verification
The hardest condition to reach from the ports is a genuine correctable syndrome. Random code pairs almost never place a difference in all twelve pairs at once. The bench therefore chooses a target byte and bit, and builds a syndrome with exactly one bit set in every pair, the odd bit carrying the location. It scatters that syndrome back into the byte layout and XORs it onto a random recomputed code. Near misses are produced the same way: one pair is left empty, a single bit is flipped at every field boundary of the byte reordering, and the all-ones syndrome is used. The bench also issues back-to-back requests, so that the done strobe stays high through chained requests.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    localparam int BYTE_ADDR_W = 9;
    localparam int BIT_SEL_W   = 3;
    localparam int PAIR_CNT    = BYTE_ADDR_W + BIT_SEL_W;
    localparam int SYN_W       = 2 * PAIR_CNT;

    typedef enum logic [1:0] {
        VERDICT_CLEAN     = 2'b00,
        VERDICT_FIXED     = 2'b01,
        VERDICT_CODE_ONLY = 2'b10,
        VERDICT_FATAL     = 2'b11
    } verdict_e;

    typedef enum logic {
        S_WAIT = 1'b0,
        S_DONE = 1'b1
    } fix_state_e;

endpackage

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
    import ecc_fix_pkg::*;
(
    input  logic [SYN_W-1:0] code_bytes,
    output logic [SYN_W-1:0] code_word
);
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] b2;

    assign b0 = code_bytes[7:0];
    assign b1 = code_bytes[15:8];
    assign b2 = code_bytes[23:16];

    // Ascending parity order: low column bits, then the line bytes, then the two top line bits
    assign code_word = {b2[1:0], b1, b0, b2[7:2]};
endmodule

// File: rtl/ecc_syndrome_eval.sv
module ecc_syndrome_eval
    import ecc_fix_pkg::*;
(
    input  logic [SYN_W-1:0]       syn,
    output verdict_e               verdict,
    output logic [BYTE_ADDR_W-1:0] loc_byte,
    output logic [BIT_SEL_W-1:0]   loc_bit
);
    logic [PAIR_CNT-1:0] pair_hit;
    logic [PAIR_CNT-1:0] pair_loc;
    logic                all_pairs;
    logic                single_hit;
    logic                any_hit;

    genvar k;
    generate
        for (k = 0; k < PAIR_CNT; k++) begin : g_pair
            assign pair_hit[k] = syn[2*k] | syn[2*k+1];
            assign pair_loc[k] = syn[2*k+1];
        end
    endgenerate

    assign all_pairs  = &pair_hit;
    assign any_hit    = |syn;
    assign single_hit = any_hit && ((syn & (syn - 1'b1)) == '0);

    always_comb begin
        verdict  = VERDICT_FATAL;
        loc_byte = '0;
        loc_bit  = '0;
        if (!any_hit) begin
            verdict = VERDICT_CLEAN;
        end else if (all_pairs) begin
            verdict  = VERDICT_FIXED;
            loc_bit  = pair_loc[BIT_SEL_W-1:0];
            loc_byte = pair_loc[PAIR_CNT-1:BIT_SEL_W];
        end else if (single_hit) begin
            verdict = VERDICT_CODE_ONLY;
        end
    end

    always_comb begin
        if (single_hit) begin
            AST_SINGLE_NOT_FIXABLE: assert (verdict == VERDICT_CODE_ONLY); // R6
        end
    end
endmodule

// File: rtl/sector_ecc_fixer.sv
module sector_ecc_fixer
    import ecc_fix_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chk_req,
    input  logic [23:0] code_stored,
    input  logic [23:0] code_calc,
    output logic        chk_done,
    output logic [1:0]  chk_status,
    output logic [8:0]  fix_byte,
    output logic [2:0]  fix_bit
);
    fix_state_e               state_q;
    fix_state_e               state_d;
    logic [SYN_W-1:0]         word_stored;
    logic [SYN_W-1:0]         word_calc;
    logic [SYN_W-1:0]         syndrome;
    verdict_e                 verdict;
    logic [BYTE_ADDR_W-1:0]   loc_byte;
    logic [BIT_SEL_W-1:0]     loc_bit;

    ecc_code_pack u_pack_stored (
        .code_bytes (code_stored),
        .code_word  (word_stored)
    );

    ecc_code_pack u_pack_calc (
        .code_bytes (code_calc),
        .code_word  (word_calc)
    );

    assign syndrome = word_stored ^ word_calc;

    ecc_syndrome_eval u_eval (
        .syn      (syndrome),
        .verdict  (verdict),
        .loc_byte (loc_byte),
        .loc_bit  (loc_bit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT:  state_d = chk_req ? S_DONE : S_WAIT;
            S_DONE:  state_d = chk_req ? S_DONE : S_WAIT;
            default: state_d = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_status <= VERDICT_CLEAN;
            fix_byte   <= '0;
            fix_bit    <= '0;
        end else if (chk_req) begin
            chk_status <= verdict;
            fix_byte   <= loc_byte;
            fix_bit    <= loc_bit;
        end
    end

    assign chk_done = (state_q == S_DONE);

    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> chk_done); // R9
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_req |=> !chk_done); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_req |=> $stable(chk_status) && $stable(fix_byte) && $stable(fix_bit)); // R9
    AST_EQUAL_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && code_stored == code_calc) |=> chk_status == 2'b00); // R1
    AST_LOC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_status != 2'b01) |-> (fix_byte == '0 && fix_bit == '0)); // R8
    AST_ONE_BIT_CODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && $countones(code_stored ^ code_calc) == 1) |=> chk_status == 2'b10); // R6
endmodule

// File: tb/sector_ecc_fixer_bench.sv
`timescale 1ns/1ps
module sector_ecc_fixer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_req = 1'b0;
    logic [23:0] code_stored = '0;
    logic [23:0] code_calc = '0;
    logic        chk_done;
    logic [1:0]  chk_status;
    logic [8:0]  fix_byte;
    logic [2:0]  fix_bit;

    int checks = 0;
    int fails = 0;
    bit checking = 1'b0;

    logic       e_done = 1'b0;
    logic [1:0] e_status = 2'b00;
    logic [8:0] e_byte = '0;
    logic [2:0] e_bit = '0;

    always #2.5 clk = ~clk;

    sector_ecc_fixer u_sector_ecc_fixer (
        .clk(clk), .rst_n(rst_n), .chk_req(chk_req),
        .code_stored(code_stored), .code_calc(code_calc),
        .chk_done(chk_done), .chk_status(chk_status),
        .fix_byte(fix_byte), .fix_bit(fix_bit)
    );

    // R2: position in the flat byte bus of ascending-order bit i
    function automatic int flat_pos(int i);
        if (i < 6)       return 18 + i;
        else if (i < 14) return i - 6;
        else if (i < 22) return i + 8 - 14;
        else             return 16 + i - 22;
    endfunction

    function automatic logic [23:0] to_word(logic [23:0] bytes);
        logic [23:0] w = '0;
        for (int i = 0; i < 24; i++) w[i] = bytes[flat_pos(i)];
        return w;
    endfunction

    function automatic logic [23:0] to_bytes(logic [23:0] w);
        logic [23:0] b = '0;
        for (int i = 0; i < 24; i++) b[flat_pos(i)] = w[i];
        return b;
    endfunction

    // Syndrome for a correctable fault: one bit per pair, odd bit = location bit
    function automatic logic [23:0] fix_syn(int byte_a, int bit_a);
        logic [23:0] d = '0;
        int loc = (byte_a << 3) | bit_a;
        for (int k = 0; k < 12; k++) begin
            d[2*k+1] = loc[k];
            d[2*k]   = ~loc[k];
        end
        return d;
    endfunction

    // Behavioural reference model, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            e_done <= 1'b0; e_status <= 2'b00; e_byte <= '0; e_bit <= '0;
        end else begin
            e_done <= chk_req;
            if (chk_req) begin
                logic [23:0] d;
                int ones;
                int pairs;
                int addr;
                int bsel;
                d = to_word(code_stored) ^ to_word(code_calc);
                ones = 0; pairs = 0; addr = 0; bsel = 0;
                for (int i = 0; i < 24; i++) if (d[i]) ones++;
                for (int k = 0; k < 12; k++) if (d[2*k] || d[2*k+1]) pairs++;
                for (int j = 0; j < 3; j++) if (d[2*j+1]) bsel += (1 << j);
                for (int j = 0; j < 9; j++) if (d[7+2*j]) addr += (1 << j);
                if (ones == 0) begin
                    e_status <= 2'b00; e_byte <= '0; e_bit <= '0;
                end else if (pairs == 12) begin
                    e_status <= 2'b01; e_byte <= 9'(addr); e_bit <= 3'(bsel);
                end else if (ones == 1) begin
                    e_status <= 2'b10; e_byte <= '0; e_bit <= '0;
                end else begin
                    e_status <= 2'b11; e_byte <= '0; e_bit <= '0;
                end
            end
        end
    end

    function automatic string status_tag(logic [1:0] s);
        case (s)
            2'b00:   return "R1";
            2'b01:   return "R3";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(negedge clk) begin
        if (checking) begin
            checks++;
            if (chk_done !== e_done) begin
                fails++;
                $display("FAIL R9 done actual=%0b expected=%0b", chk_done, e_done);
            end
            checks++;
            if (chk_status !== e_status) begin
                fails++;
                $display("FAIL %s status actual=%0b expected=%0b", status_tag(e_status), chk_status, e_status);
            end
            checks++;
            if (fix_byte !== e_byte) begin
                fails++;
                $display("FAIL %s byte actual=%0d expected=%0d", (e_status == 2'b01) ? "R5" : "R8", fix_byte, e_byte);
            end
            checks++;
            if (fix_bit !== e_bit) begin
                fails++;
                $display("FAIL %s bit actual=%0d expected=%0d", (e_status == 2'b01) ? "R4" : "R8", fix_bit, e_bit);
            end
        end
    end

    task automatic send(logic [23:0] calc, logic [23:0] stored, bit keep);
        @(negedge clk);
        code_calc = calc; code_stored = stored; chk_req = 1'b1;
        if (!keep) begin
            @(negedge clk);
            chk_req = 1'b0;
        end
    endtask

    task automatic send_syn(logic [23:0] calc, logic [23:0] dword, bit keep);
        send(calc, calc ^ to_bytes(dword), keep);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (chk_done !== 1'b0 || chk_status !== 2'b00 || fix_byte !== '0 || fix_bit !== '0) begin
            fails++;
            $display("FAIL R10 reset actual=%0b/%0b/%0d/%0d expected=0/0/0/0", chk_done, chk_status, fix_byte, fix_bit);
        end
        rst_n = 1'b1;
        checking = 1'b1;
        @(negedge clk);

        // R1: identical codes
        send(24'hA5C3_3C, 24'hA5C3_3C, 0);
        send(24'h000000, 24'h000000, 0);
        // R3 R4 R5: correctable at corners and interior
        send_syn(24'h123456, fix_syn(0, 0), 0);
        send_syn(24'hFEDCBA, fix_syn(511, 7), 0);
        send_syn(24'h0F0F0F, fix_syn(341, 5), 0);
        send_syn(24'h777777, fix_syn(170, 2), 0);
        // R3: all-ones syndrome has every pair hit
        send_syn(24'h55AA55, 24'hFFFFFF, 0);
        // R2 R6: one-bit faults at every field boundary of the reordering
        send_syn(24'h3C3C3C, 24'h000001, 0);
        send_syn(24'h3C3C3C, 24'h000020, 0);
        send_syn(24'h3C3C3C, 24'h000040, 0);
        send_syn(24'h3C3C3C, 24'h002000, 0);
        send_syn(24'h3C3C3C, 24'h004000, 0);
        send_syn(24'h3C3C3C, 24'h200000, 0);
        send_syn(24'h3C3C3C, 24'h400000, 0);
        send_syn(24'h3C3C3C, 24'h800000, 0);
        // R2: raw flips on byte 2 low bits land at the top of the word
        send(24'h000000, 24'h010000, 0);
        // R7: two bits, and a full syndrome with one pair emptied
        send_syn(24'h111111, 24'h000003, 0);
        send_syn(24'h111111, fix_syn(100, 3) & ~24'h000C00, 0);
        send_syn(24'h111111, fix_syn(1, 1) & ~24'hC00000, 0);
        // R9: back-to-back requests, then idle hold
        send_syn(24'hABCDEF, fix_syn(257, 6), 1);
        send_syn(24'hABCDEF, 24'h000101, 1);
        send(24'h424242, 24'h424242, 1);
        send_syn(24'h010203, fix_syn(3, 4), 0);
        code_stored = 24'hFFFFFF; code_calc = 24'h000000;
        repeat (4) @(negedge clk);
        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [23:0] c;
            c = 24'($urandom);
            case (n % 4)
                0: send_syn(c, fix_syn($urandom_range(511), $urandom_range(7)), (n % 3) == 0);
                1: send_syn(c, 24'(1) << $urandom_range(23), 0);
                2: send(c, 24'($urandom), (n % 5) == 0);
                default: send(c, c, 0);
            endcase
        end
        @(negedge clk);
        chk_req = 1'b0;
        repeat (3) @(negedge clk);
        checking = 1'b0;
        finish_run();
    end
endmodule